// File: doc/BRIEF.md
# SPI Register Port with One-Frame-Late Read Replies

This block is an SPI target in mode 0 that gives a host access to a small bank of 8-bit control registers. It also gives read access to an equal number of 8-bit status values that a peripheral core drives in. Every transaction is one 16-bit frame bounded by chip select. The first byte carries the operation and the register index. The second byte carries write data, or a read option.

A write takes effect as soon as its frame closes. A read frame only queues a request. The register value is shifted back to the host during the next frame, whatever that frame carries. The host can therefore chain reads and writes with chip select released between frames. It sends one trailing dummy frame to collect the last reply.

The serial pins are brought into the system clock domain through two-flop synchronizers. All decoding and register updates run on the system clock, so the system clock must run several times faster than SCLK.

Top module: `spi_regport`

## Requirements
- R1: SPI mode 0. MOSI is sampled on the SCLK rising edge and MISO is updated after the falling edge, both MSB first. The first reply bit is on MISO before the first rising edge of a frame.
- R2: A frame is accepted only if exactly 16 SCLK rising edges occur while chip select is low. Any other count discards the frame, and such a frame never changes a register.
- R3: Frame bit 15 = 1 is a write. Bits 14:8 give the register index and bits 7:0 the value. The addressed control register holds the value after chip select rises.
- R4: Frame bit 15 = 0 is a read of the index in bits 14:8. Bit 7 = 1 selects the control register and bit 7 = 0 selects the status input. Bits 6:0 are ignored.
- R5: The reply to a read is shifted out during the next frame. The reply word has bits 15:14 = 0, bits 13:8 = 0, and the register value in bits 7:0. The value is taken when the read frame closes.
- R6: The frame after an accepted write frame shifts out an all-zero reply.
- R7: The frame after a discarded frame shifts out an all-zero reply, which replaces any pending read reply.
- R8: An index at or above NREGS is out of range. A write to it changes nothing, and a read of it returns zero.
- R9: Synchronous reset clears every control register and the pending reply, and drives MISO low.
- R10: MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing each 16-bit word |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial reply data to host |
| status_in | input | NREGS*8 | Status values from the core, register i in bits 8i+7:8i |
| ctrl_out | output | NREGS*8 | Control register contents, register i in bits 8i+7:8i |

## Verification
The assertions check four rules on every cycle. A control register changes only on the cycle after a write strobe, and then holds exactly the strobed value. A discarded frame or an accepted write always leaves a zero pending reply. MISO moves only on a synchronized falling edge or at frame start. Only the bench's frame sequences show the things that span frames. These are the one-frame delay of replies, the choice between control and status contents, rejection of out-of-range indices, and a pending reply lost to a short or long frame.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int FRAME_BITS   = 16;
    localparam int PAYLOAD_BITS = 14;
    localparam int INDEX_BITS   = 7;
    localparam int DATA_BITS    = 8;
    localparam int COUNT_BITS   = $clog2(FRAME_BITS) + 1;

    typedef struct packed {
        logic                  is_write;
        logic [INDEX_BITS-1:0] index;
        logic [DATA_BITS-1:0]  data;
    } frame_t;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_READ_CTRL,
        OP_READ_STAT
    } op_e;

    function automatic op_e decode_op(frame_t f);
        if (f.is_write)
            return OP_WRITE;
        else if (f.data[DATA_BITS-1])
            return OP_READ_CTRL;
        else
            return OP_READ_STAT;
    endfunction

    function automatic logic [PAYLOAD_BITS-1:0] make_payload(logic [DATA_BITS-1:0] v);
        return {{(PAYLOAD_BITS-DATA_BITS){1'b0}}, v};
    endfunction

    function automatic logic [FRAME_BITS-1:0] make_word(logic [PAYLOAD_BITS-1:0] p);
        return {{(FRAME_BITS-PAYLOAD_BITS){1'b0}}, p};
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_end,
    output logic cs_active,
    output logic mosi_s
);
    logic [STAGES:0]   sclk_q;
    logic [STAGES:0]   cs_q;
    logic [STAGES-1:0] mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[STAGES-1:0], sclk};
            cs_q   <= {cs_q[STAGES-1:0], cs_n};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
    assign cs_start  = ~cs_q[STAGES-1] & cs_q[STAGES];
    assign cs_end    = cs_q[STAGES-1] & ~cs_q[STAGES];
    assign cs_active = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_regport_shifter.sv
module spi_regport_shifter
    import spi_regport_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk_rise,
    input  logic                    sclk_fall,
    input  logic                    cs_start,
    input  logic                    cs_end,
    input  logic                    cs_active,
    input  logic                    mosi_s,
    input  logic [PAYLOAD_BITS-1:0] reply,
    output frame_t                  rx_frame,
    output logic                    frame_ok,
    output logic                    frame_bad,
    output logic                    miso
);
    localparam logic [COUNT_BITS-1:0] FULL  = COUNT_BITS'(FRAME_BITS);
    localparam logic [COUNT_BITS-1:0] SATUR = '1;

    logic [FRAME_BITS-1:0] rx_sr;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [COUNT_BITS-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr     <= '0;
            tx_sr     <= '0;
            bit_cnt   <= '0;
            frame_ok  <= 1'b0;
            frame_bad <= 1'b0;
        end else begin
            frame_ok  <= cs_end && (bit_cnt == FULL);
            frame_bad <= cs_end && (bit_cnt != FULL);
            if (cs_start) begin
                bit_cnt <= '0;
                tx_sr   <= make_word(reply);
            end else if (cs_active) begin
                if (sclk_rise) begin
                    rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
                    if (bit_cnt != SATUR)
                        bit_cnt <= bit_cnt + 1'b1;
                end
                if (sclk_fall)
                    tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign rx_frame = frame_t'(rx_sr);
    assign miso     = cs_active & tx_sr[FRAME_BITS-1];
endmodule

// File: rtl/spi_regport_exec.sv
module spi_regport_exec
    import spi_regport_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_ok,
    input  logic                        frame_bad,
    input  frame_t                      rx_frame,
    input  logic [NREGS*DATA_BITS-1:0]  status_in,
    input  logic [NREGS*DATA_BITS-1:0]  ctrl_in,
    output logic                        wr_stb,
    output logic [INDEX_BITS-1:0]       wr_addr,
    output logic [DATA_BITS-1:0]        wr_data,
    output logic [PAYLOAD_BITS-1:0]     reply
);
    op_e                  op;
    logic                 in_range;
    logic [DATA_BITS-1:0] ctrl_sel;
    logic [DATA_BITS-1:0] stat_sel;
    logic [DATA_BITS-1:0] read_val;

    assign op       = decode_op(rx_frame);
    assign in_range = int'(rx_frame.index) < NREGS;

    always_comb begin
        ctrl_sel = '0;
        stat_sel = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (int'(rx_frame.index) == i) begin
                ctrl_sel = ctrl_in[i*DATA_BITS +: DATA_BITS];
                stat_sel = status_in[i*DATA_BITS +: DATA_BITS];
            end
        end
    end

    always_comb begin
        unique case (op)
            OP_READ_CTRL: read_val = ctrl_sel;
            OP_READ_STAT: read_val = stat_sel;
            default:      read_val = '0;
        endcase
    end

    assign wr_stb  = frame_ok && (op == OP_WRITE) && in_range;
    assign wr_addr = rx_frame.index;
    assign wr_data = rx_frame.data;

    always_ff @(posedge clk) begin
        if (rst)
            reply <= '0;
        else if (frame_bad)
            reply <= '0;
        else if (frame_ok)
            reply <= in_range ? make_payload(read_val) : '0;
    end
endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile
    import spi_regport_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_stb,
    input  logic [INDEX_BITS-1:0]      wr_addr,
    input  logic [DATA_BITS-1:0]       wr_data,
    output logic [NREGS*DATA_BITS-1:0] regs_flat
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DATA_BITS-1:0] value;
        always_ff @(posedge clk) begin
            if (rst)
                value <= '0;
            else if (wr_stb && int'(wr_addr) == g)
                value <= wr_data;
        end
        assign regs_flat[g*DATA_BITS +: DATA_BITS] = value;
    end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [NREGS*DATA_BITS-1:0] status_in,
    output logic [NREGS*DATA_BITS-1:0] ctrl_out
);
    logic                    sclk_rise, sclk_fall, cs_start, cs_end, cs_active, mosi_s;
    frame_t                  rx_frame;
    logic                    frame_ok, frame_bad;
    logic [PAYLOAD_BITS-1:0] reply;
    logic                    wr_stb;
    logic [INDEX_BITS-1:0]   wr_addr;
    logic [DATA_BITS-1:0]    wr_data;

    spi_regport_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_end(cs_end),
        .cs_active(cs_active), .mosi_s(mosi_s)
    );

    spi_regport_shifter u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_end(cs_end), .cs_active(cs_active),
        .mosi_s(mosi_s), .reply(reply),
        .rx_frame(rx_frame), .frame_ok(frame_ok), .frame_bad(frame_bad),
        .miso(spi_miso)
    );

    spi_regport_exec #(.NREGS(NREGS)) u_exec (
        .clk(clk), .rst(rst),
        .frame_ok(frame_ok), .frame_bad(frame_bad), .rx_frame(rx_frame),
        .status_in(status_in), .ctrl_in(ctrl_out),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .reply(reply)
    );

    spi_regport_regfile #(.NREGS(NREGS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .regs_flat(ctrl_out)
    );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter int NREGS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cs_active,
    input logic                       cs_start,
    input logic                       sclk_fall,
    input logic                       miso,
    input frame_t                     rx_frame,
    input logic                       frame_ok,
    input logic                       frame_bad,
    input logic [PAYLOAD_BITS-1:0]    reply,
    input logic                       wr_stb,
    input logic [INDEX_BITS-1:0]      wr_addr,
    input logic [DATA_BITS-1:0]       wr_data,
    input logic [NREGS*DATA_BITS-1:0] ctrl_out
);
    function automatic logic [DATA_BITS-1:0] word_at(logic [NREGS*DATA_BITS-1:0] flat,
                                                     logic [INDEX_BITS-1:0] idx);
        logic [DATA_BITS-1:0] w;
        w = '0;
        for (int i = 0; i < NREGS; i++)
            if (int'(idx) == i) w = flat[i*DATA_BITS +: DATA_BITS];
        return w;
    endfunction

    // R3: a strobed write lands in the register file on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (word_at(ctrl_out, $past(wr_addr)) == $past(wr_data)));

    // R2 and R8: control registers change only after a write strobe
    a_r2_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(ctrl_out));

    // R7: a discarded frame clears the pending reply
    a_r7_bad_clears_reply: assert property (@(posedge clk) disable iff (rst)
        frame_bad |=> (reply == '0));

    // R6: an accepted write frame leaves a zero reply
    a_r6_write_zero_reply: assert property (@(posedge clk) disable iff (rst)
        (frame_ok && rx_frame.is_write) |=> (reply == '0));

    // R1: MISO moves only on a synchronized falling edge or at frame start
    a_r1_miso_holds: assert property (@(posedge clk) disable iff (rst)
        (cs_active && !sclk_fall && !cs_start) |=> (!cs_active || $stable(miso)));
endmodule

bind spi_regport spi_regport_chk #(.NREGS(NREGS)) u_chk (
    .clk(clk), .rst(rst),
    .cs_active(cs_active), .cs_start(cs_start), .sclk_fall(sclk_fall),
    .miso(spi_miso), .rx_frame(rx_frame),
    .frame_ok(frame_ok), .frame_bad(frame_bad), .reply(reply),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_out(ctrl_out)
);

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
    localparam int NREGS = 8;
    localparam int HALF  = 8;
    localparam int NVEC  = 10;

    // each entry: frame sent (31:16), reply expected in that same frame (15:0)
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h825A, 16'h0000},   // R3 write reg2
        {16'h0280, 16'h0000},   // R6 reply after write is zero; read ctrl 2
        {16'h0500, 16'h005A},   // R5 ctrl 2 returns; read status 5
        {16'h87FF, 16'h0035},   // R4 status 5; write reg7
        {16'h07FF, 16'h0000},   // R4 read ctrl 7, low bits ignored
        {16'h0000, 16'h00FF},   // R4 ctrl 7 returns; read status 0
        {16'hC011, 16'h0030},   // R8 write index 0x40
        {16'h4080, 16'h0000},   // R8 read ctrl index 0x40
        {16'h0100, 16'h0000},   // R8 out of range read gives zero; read status 1
        {16'h80C3, 16'h0031}    // R5 status 1 returns; write reg0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [NREGS*8-1:0] status_in;
    logic [NREGS*8-1:0] ctrl_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_regport #(.NREGS(NREGS)) u0 (
        .clk(clk), .rst(rst),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .status_in(status_in), .ctrl_out(ctrl_out)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? tx[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 16) rx[15-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) status_in[i*8 +: 8] = 8'h30 + 8'(i);
    end

    initial begin
        logic [15:0] rx;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(64'(ctrl_out), 64'h0, "R9 reset clears control registers");
        check(64'(miso), 64'h0, "R9 reset MISO low");

        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][31:16], 16, rx);
            check(64'(rx), 64'(VEC[v][15:0]), $sformatf("R5 vector %0d reply", v));
        end
        check(64'(ctrl_out), 64'hFF00_0000_005A_00C3, "R3 R8 register contents after table");

        // R10: MISO low while chip select is high
        xfer(16'h0680, 16, rx);
        repeat (5) @(negedge clk);
        check(64'(miso), 64'h0, "R10 idle MISO low");
        xfer(16'h0000, 16, rx);
        check(64'(rx), 64'h0, "R4 ctrl 6 read zero");

        // R2 R7: short frame discards write and pending reply
        xfer(16'h0280, 16, rx);
        xfer(16'h83AA, 12, rx);
        xfer(16'h0000, 16, rx);
        check(64'(rx), 64'h0, "R7 short frame clears pending reply");
        check(64'(ctrl_out[3*8 +: 8]), 64'h0, "R2 short frame write ignored");

        // R2 R7: long frame
        xfer(16'h0280, 16, rx);
        xfer(16'h84AA, 17, rx);
        xfer(16'h0000, 16, rx);
        check(64'(rx), 64'h0, "R7 long frame clears pending reply");
        check(64'(ctrl_out[4*8 +: 8]), 64'h0, "R2 long frame write ignored");

        // R1: back-to-back reads with alternating bit patterns
        xfer(16'h8555, 16, rx);
        xfer(16'h0580, 16, rx);
        xfer(16'h0780, 16, rx);
        check(64'(rx), 64'h0055, "R1 reply 0x55 bit order");
        xfer(16'h0000, 16, rx);
        check(64'(rx), 64'h00FF, "R1 reply 0xFF bit order");

        // R9: reset mid-run clears registers and pending reply
        xfer(16'h0280, 16, rx);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);
        check(64'(ctrl_out), 64'h0, "R9 reset clears registers mid-run");
        xfer(16'h0000, 16, rx);
        check(64'(rx), 64'h0, "R9 reset clears pending reply");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule